// File: doc/BRIEF.md
# I2C Master Transmit Byte Queue with NAK Halt

This block is the transmit side of an I2C master. Software pushes bytes into a 64-deep queue through a data write port. A control write port carries an enable bit and a flush bit. While enabled, a drain sequencer hands the oldest byte to the bit-level bus engine with a request/done handshake. For each byte, the engine reports whether the target acknowledged it. START and STOP generation and the receive path are outside this block.

An acknowledged byte is removed from the queue and the next one follows. A NAK also removes the refused byte, then freezes the sequencer. The bytes behind it stay queued and are not offered until software writes the flush bit. This sets a sticky no-ack status flag and raises a halt indication in the control readback. Draining the last byte with an acknowledge sets a sticky drained flag. Pushing into a full queue drops the byte and sets a sticky overflow flag. Status flags are cleared by writing ones to them.

Top module: `i2c_txq`

## Requirements
- R1: Up to 64 bytes written while the queue is not full are each offered on `tx_byte` exactly once, in write order.
- R2: With control bit 6 (enable) at 0, `tx_req` stays low; bit 6 reads back at `ctl_rdata[6]`.
- R3: A data write while 64 bytes are queued is dropped and sets status bit 2 (overflow); the 64 queued bytes are unaffected.
- R4: A byte answered with `tx_nak`=1 sets status bit 0 (no-ack), and no further byte is offered until a flush.
- R5: After a NAK, `ctl_rdata[3]` reads 1 until a flush.
- R6: A control write with bit 7 set empties the queue in one cycle and clears the halt. Bit 7 is not stored and `ctl_rdata[7]` reads 0. Bit 6 written in the same write takes effect too.
- R7: Status bit 1 (drained) is set when an acknowledged byte leaves the queue empty. `fstat_rdata[4]` reads 1 exactly when the queue is empty.
- R8: A status write clears the flags whose `isr_clr` bit is 1 and leaves the others. A flag set in the same cycle stays set. `isr_rdata[7:3]` reads 0.
- R9: After reset: `isr_rdata`=0x00, `ctl_rdata`=0x00, `fstat_rdata`=0x10 and `tx_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_wr | input | 1 | Push strobe for the data register |
| dat_byte | input | 8 | Byte to push |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wbits | input | 2 | Control write data bits 7 (flush) and 6 (enable) |
| isr_wr | input | 1 | Status register write strobe |
| isr_clr | input | 3 | Write-one-to-clear mask for status bits 2:0 |
| ctl_rdata | output | 8 | Control readback: bit 6 enable, bit 3 NAK halt |
| isr_rdata | output | 8 | Status: bit 0 no-ack, bit 1 drained, bit 2 overflow |
| fstat_rdata | output | 8 | Queue status: bit 4 empty |
| tx_req | output | 1 | Byte offered to the bus engine |
| tx_byte | output | 8 | Offered byte |
| tx_done | input | 1 | One-cycle pulse from the bus engine: byte finished |
| tx_nak | input | 1 | Valid with `tx_done`: target did not acknowledge |

## Verification
Two situations are hard to reach. One is a NAK that arrives while bytes are still queued behind it. The other is a push into a queue that is exactly full. The bench models the bus engine and can refuse the byte at any chosen index with a varying reply delay. It sweeps queue lengths against every NAK position, then checks that nothing more is offered until the flush. To reach the full queue, the bench fills it with enable low. It pushes one extra byte, then enables the drain and counts what comes out.

// File: rtl/i2c_txq_pkg.sv
package i2c_txq_pkg;
    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_SEND = 2'd1,
        DR_HALT = 2'd2
    } drain_st_e;

    localparam int ISR_NOACK   = 0;
    localparam int ISR_DRAINED = 1;
    localparam int ISR_OVF     = 2;
    localparam int CTL_HALT    = 3;
    localparam int CTL_EN      = 6;
    localparam int FST_EMPTY   = 4;
endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full,
    output logic          last_one,
    output logic          ovf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [CW-1:0] wr;
        logic [CW-1:0] rd;
    } ptr_t;

    ptr_t          s_q, s_d;
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] fill;
    logic          do_push;

    assign fill     = s_q.wr - s_q.rd;
    assign full     = (fill == CW'(DEPTH));
    assign empty    = (fill == '0);
    assign last_one = (fill == CW'(1));
    assign do_push  = push && !full && !flush;
    assign ovf_evt  = push && full && !flush;
    assign head     = mem[s_q.rd[AW-1:0]];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_push)       s_d.wr = s_q.wr + CW'(1);
            if (pop && !empty) s_d.rd = s_q.rd + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[s_q.wr[AW-1:0]] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R1
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !flush && !pop) |=> full); // R3
endmodule

// File: rtl/txq_drain.sv
module txq_drain
    import i2c_txq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic flush,
    input  logic empty,
    input  logic last_one,
    input  logic byte_done,
    input  logic byte_nak,
    output logic byte_req,
    output logic pop,
    output logic halted,
    output logic nak_evt,
    output logic drained_evt
);
    typedef struct packed {
        drain_st_e st;
    } drain_t;

    drain_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        pop         = 1'b0;
        nak_evt     = 1'b0;
        drained_evt = 1'b0;
        case (r_q.st)
            DR_IDLE: begin
                if (enable && !empty && !flush) r_d.st = DR_SEND;
            end
            DR_SEND: begin
                if (flush) begin
                    r_d.st = DR_IDLE;
                end else if (byte_done) begin
                    pop = 1'b1;
                    if (byte_nak) begin
                        nak_evt = 1'b1;
                        r_d.st  = DR_HALT;
                    end else begin
                        drained_evt = last_one;
                        r_d.st      = DR_IDLE;
                    end
                end
            end
            DR_HALT: begin
                if (flush) r_d.st = DR_IDLE;
            end
            default: r_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: DR_IDLE};
        else        r_q <= r_d;
    end

    assign byte_req = (r_q.st == DR_SEND);
    assign halted   = (r_q.st == DR_HALT);

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !byte_req); // R4
    AST_NAK_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_req && byte_done && byte_nak && !flush) |=> (halted && !byte_req)); // R4
    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !byte_req) |=> !byte_req); // R2
endmodule

// File: rtl/txq_regs.sv
module txq_regs
    import i2c_txq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [7:6] ctl_wbits,
    input  logic       isr_wr,
    input  logic [2:0] isr_clr,
    input  logic       nak_evt,
    input  logic       drained_evt,
    input  logic       ovf_evt,
    input  logic       halted,
    input  logic       empty,
    output logic       enable,
    output logic       flush,
    output logic [7:0] ctl_rdata,
    output logic [7:0] isr_rdata,
    output logic [7:0] fstat_rdata
);
    typedef struct packed {
        logic       en;
        logic [2:0] isr;
    } regs_t;

    regs_t g_q, g_d;
    logic [2:0] set_v;

    assign set_v = {ovf_evt, drained_evt, nak_evt};
    assign flush = ctl_wr && ctl_wbits[7];

    always_comb begin
        g_d = g_q;
        if (ctl_wr) g_d.en = ctl_wbits[6];
        if (isr_wr) g_d.isr = g_q.isr & ~isr_clr;
        g_d.isr = g_d.isr | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign enable = g_q.en;

    always_comb begin
        ctl_rdata              = '0;
        ctl_rdata[CTL_EN]      = g_q.en;
        ctl_rdata[CTL_HALT]    = halted;
        isr_rdata              = '0;
        isr_rdata[ISR_NOACK]   = g_q.isr[0];
        isr_rdata[ISR_DRAINED] = g_q.isr[1];
        isr_rdata[ISR_OVF]     = g_q.isr[2];
        fstat_rdata            = '0;
        fstat_rdata[FST_EMPTY] = empty;
    end

    AST_CLR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_wr && isr_clr[0] && !nak_evt) |=> !isr_rdata[ISR_NOACK]); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rdata[ISR_NOACK] && !isr_wr) |=> isr_rdata[ISR_NOACK]); // R8
    AST_NAK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        nak_evt |=> (isr_rdata[ISR_NOACK] && ctl_rdata[CTL_HALT])); // R5
endmodule

// File: rtl/i2c_txq.sv
module i2c_txq #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dat_wr,
    input  logic [DW-1:0] dat_byte,
    input  logic          ctl_wr,
    input  logic [7:6]    ctl_wbits,
    input  logic          isr_wr,
    input  logic [2:0]    isr_clr,
    output logic [7:0]    ctl_rdata,
    output logic [7:0]    isr_rdata,
    output logic [7:0]    fstat_rdata,
    output logic          tx_req,
    output logic [DW-1:0] tx_byte,
    input  logic          tx_done,
    input  logic          tx_nak
);
    logic enable, flush, empty, full, last_one, ovf_evt;
    logic pop, halted, nak_evt, drained_evt;

    txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(dat_wr), .din(dat_byte),
        .pop(pop), .head(tx_byte), .empty(empty), .full(full),
        .last_one(last_one), .ovf_evt(ovf_evt)
    );

    txq_drain u_drain (
        .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush), .empty(empty),
        .last_one(last_one), .byte_done(tx_done), .byte_nak(tx_nak),
        .byte_req(tx_req), .pop(pop), .halted(halted), .nak_evt(nak_evt),
        .drained_evt(drained_evt)
    );

    txq_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wbits(ctl_wbits),
        .isr_wr(isr_wr), .isr_clr(isr_clr), .nak_evt(nak_evt),
        .drained_evt(drained_evt), .ovf_evt(ovf_evt), .halted(halted),
        .empty(empty), .enable(enable), .flush(flush), .ctl_rdata(ctl_rdata),
        .isr_rdata(isr_rdata), .fstat_rdata(fstat_rdata)
    );

    AST_DRAIN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fstat_rdata[4] && !dat_wr) |=> (fstat_rdata[4] && !tx_req)); // R7
    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !fstat_rdata[4]); // R3
endmodule

// File: tb/i2c_txq_bench.sv
module i2c_txq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dat_wr = 1'b0;
    logic [7:0] dat_byte = '0;
    logic       ctl_wr = 1'b0;
    logic [7:6] ctl_wbits = '0;
    logic       isr_wr = 1'b0;
    logic [2:0] isr_clr = '0;
    logic [7:0] ctl_rdata, isr_rdata, fstat_rdata, tx_byte;
    logic       tx_req;
    logic       tx_done = 1'b0;
    logic       tx_nak = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [7:0] got [0:127];
    int got_n = 0;
    int nak_at = -1;
    int dly = 0;

    always #10 clk = ~clk;

    i2c_txq u_i2c_txq (
        .clk(clk), .rst_n(rst_n), .dat_wr(dat_wr), .dat_byte(dat_byte),
        .ctl_wr(ctl_wr), .ctl_wbits(ctl_wbits), .isr_wr(isr_wr), .isr_clr(isr_clr),
        .ctl_rdata(ctl_rdata), .isr_rdata(isr_rdata), .fstat_rdata(fstat_rdata),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_done(tx_done), .tx_nak(tx_nak)
    );

    // bus engine model: replies after got_n%3 extra cycles
    always @(negedge clk) begin
        tx_done = 1'b0;
        tx_nak  = 1'b0;
        if (!rst_n || !tx_req) begin
            dly = 0;
        end else if (dly >= (got_n % 3)) begin
            if (got_n < 128) got[got_n] = tx_byte;
            tx_nak  = (got_n == nak_at);
            tx_done = 1'b1;
            got_n   = got_n + 1;
            dly     = 0;
        end else begin
            dly = dly + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int n, input int i);
        return 8'((n * 7 + i * 13 + 5) & 255);
    endfunction

    task automatic wr_ctl(input logic [1:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wbits = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_isr(input logic [2:0] v);
        @(negedge clk); isr_wr = 1'b1; isr_clr = v;
        @(negedge clk); isr_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); dat_wr = 1'b1; dat_byte = b;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic run_case(input int n, input int k);
        int exp_n;
        wr_ctl(2'b10);
        wr_isr(3'b111);
        got_n = 0;
        nak_at = k;
        for (int i = 0; i < n; i++) push(pat(n, i));
        repeat (8) @(negedge clk);
        chk("R2 no request while disabled", {31'd0, tx_req}, 0);
        chk("R2 nothing offered while disabled", got_n, 0);
        wr_ctl(2'b01);
        chk("R2 enable readback", ctl_rdata, 8'h40);
        repeat (6 * n + 20) @(negedge clk);
        exp_n = (k < 0) ? n : k + 1;
        chk("R1 R4 bytes offered", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk("R1 byte order", got[i], pat(n, i));
        if (k < 0) begin
            chk("R7 drained flag", isr_rdata, 8'h02);
            chk("R7 empty after drain", fstat_rdata, 8'h10);
        end else begin
            chk("R4 no-ack flag", isr_rdata, 8'h01);
            chk("R5 halt readback", ctl_rdata, 8'h48);
            chk("R7 empty bit after nak", fstat_rdata, (k == n - 1) ? 8'h10 : 8'h00);
            wr_ctl(2'b11);
            chk("R6 flush empties", fstat_rdata, 8'h10);
            chk("R6 flush clears halt, keeps enable, bit7 not stored", ctl_rdata, 8'h40);
            repeat (10) @(negedge clk);
            chk("R4 nothing offered after flush", got_n, exp_n);
            chk("R4 no request after flush", {31'd0, tx_req}, 0);
        end
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset isr", isr_rdata, 8'h00);
        chk("R9 reset ctl", ctl_rdata, 8'h00);
        chk("R9 reset fstat", fstat_rdata, 8'h10);
        chk("R9 reset tx_req", {31'd0, tx_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int n = 1; n <= 7; n++)
            for (int k = -1; k < n; k++)
                run_case(n, k);

        // full queue, extra write dropped
        wr_ctl(2'b10);
        wr_isr(3'b111);
        got_n = 0;
        nak_at = -1;
        for (int i = 0; i < 64; i++) push(pat(64, i));
        chk("R3 full not empty", fstat_rdata, 8'h00);
        chk("R3 no overflow yet", isr_rdata, 8'h00);
        push(8'hEE);
        chk("R3 overflow flag", isr_rdata, 8'h04);
        wr_ctl(2'b01);
        repeat (64 * 6 + 40) @(negedge clk);
        chk("R3 64 bytes drained", got_n, 64);
        for (int i = 0; i < 64; i++) chk("R1 deep order", got[i], pat(64, i));
        chk("R7 drained and overflow", isr_rdata, 8'h06);

        // write-one-to-clear
        wr_isr(3'b001);
        chk("R8 clear of unset bit keeps others", isr_rdata, 8'h06);
        wr_isr(3'b100);
        chk("R8 clear overflow only", isr_rdata, 8'h02);
        wr_isr(3'b010);
        chk("R8 clear drained", isr_rdata, 8'h00);

        // set beats clear: push into full queue while clearing overflow
        wr_ctl(2'b10);
        for (int i = 0; i < 64; i++) push(8'(i));
        @(negedge clk); dat_wr = 1'b1; dat_byte = 8'h55; isr_wr = 1'b1; isr_clr = 3'b100;
        @(negedge clk); dat_wr = 1'b0; isr_wr = 1'b0;
        chk("R8 set wins over clear", isr_rdata, 8'h04);
        wr_ctl(2'b10);
        chk("R6 flush-only empties", fstat_rdata, 8'h10);
        chk("R6 flush-only disables", ctl_rdata, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule